// File: doc/BRIEF.md
# Periodic Real-Time Interrupt Timer

This block produces a timeout at a fixed, programmable rate and latches each one into a pending flag. A local enable turns that flag into an interrupt request. The counting clock comes from one of two tick enables, an internal reference or an external oscillator. Both are strobes in the single system clock domain, and a control bit picks between them. An 8-bit rate value sets the period as a modulus count multiplied by a power-of-two prescale.

Software programs the rate and control values through simple write strobes. It clears the pending flag by writing one to it. Any write of the rate value starts the period again from zero, and so does any change of the source selection. Three stop inputs decide whether counting goes on or freezes. Counting continues only when the low-power stop is the pseudo variety, the oscillator is the chosen source and the oscillator is kept running. In every other stop case the count freezes and keeps its value.

Top module: `rtt_top`

## Requirements
- R1: After synchronous reset, flag and irq are 0, the rate value is 0 (timer disabled), and both control bits are 0.
- R2: With rate bits [7:4] = P (nonzero) and bits [3:0] = M, a timeout occurs every (M+1)*2^(PRE_BASE+P) ticks of the selected source, and the flag rises at the clock edge of the last tick.
- R3: When P = 0 the timer does not count and the flag never sets.
- R4: The next period begins on the tick right after a timeout, with no lost tick, so consecutive timeouts are exactly one period apart.
- R5: Every write to the rate value restarts the period from zero, even when the value written is unchanged. The tick in the write cycle is not counted.
- R6: Control bit 1 selects the source, 0 = reference tick and 1 = oscillator tick. Ticks of the unselected source have no effect.
- R7: A control write that changes bit 1 restarts the period from zero.
- R8: While stop_mode is 1, counting halts and holds its value unless pseudo_stop, osc_keep and source bit 1 are all 1. When stop ends, counting resumes from the held value.
- R9: A clear write with data 1 clears the flag. A clear write with data 0 leaves the flag unchanged.
- R10: If a timeout and a clear with data 1 fall in the same cycle, the flag ends up set.
- R11: irq is 1 exactly when the flag is 1 and control bit 0 (interrupt enable) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Internal reference clock enable strobe |
| osc_tick | input | 1 | External oscillator clock enable strobe |
| stop_mode | input | 1 | Chip is in stop mode |
| pseudo_stop | input | 1 | Stop mode is the pseudo variety |
| osc_keep | input | 1 | Oscillator kept running in stop |
| rate_we | input | 1 | Write strobe for rate value |
| rate_wdata | input | 8 | Rate value: [7:4] prescale, [3:0] modulus |
| ctl_we | input | 1 | Write strobe for control bits |
| ctl_wdata | input | 2 | [0] interrupt enable, [1] source select |
| clr_we | input | 1 | Write strobe for flag clear |
| clr_wdata | input | 1 | 1 clears the flag, 0 does nothing |
| flag | output | 1 | Pending timeout flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that a restart or a timeout leaves both counters at zero. They also check that the modulus count never passes its limit, that a frozen source leaves the count unchanged, and that the flag follows its set, clear and hold rules, including set winning over clear. They confirm too that irq never rises without the enable bit. The bench scenarios cover the rest. These include the exact period length for several rate values and back-to-back periods with no lost tick, as well as restarts from rewrites and source changes. The bench also checks the stop-mode combinations, a frozen count that resumes where it stopped, and the deaf unselected source.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  localparam int RATE_W  = 8;
  localparam int PF_W    = 4;
  localparam int MF_W    = 4;
  localparam int CTL_W   = 2;
  localparam int CTL_IEN = 0;
  localparam int CTL_SRC = 1;

  typedef struct packed {
    logic src_osc;
    logic irq_en;
  } rtt_ctl_t;
endpackage

// File: rtl/rtt_src_gate.sv
module rtt_src_gate (
  input  logic ref_tick,
  input  logic osc_tick,
  input  logic src_osc,
  input  logic stop_mode,
  input  logic pseudo_stop,
  input  logic osc_keep,
  output logic run
);
  logic tick_sel;
  logic stop_ok;

  always_comb begin
    tick_sel = src_osc ? osc_tick : ref_tick;
    stop_ok  = pseudo_stop & osc_keep & src_osc;
    run      = tick_sel & (~stop_mode | stop_ok);
  end
endmodule

// File: rtl/rtt_count.sv
module rtt_count #(
  parameter int PRE_BASE = 10,
  parameter int PF_W     = 4,
  parameter int MF_W     = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            restart,
  input  logic [PF_W-1:0] presc_sel,
  input  logic [MF_W-1:0] mod_sel,
  output logic            timeout
);
  localparam int PW = PRE_BASE + (2**PF_W) - 1;
  localparam int EW = $clog2(PW + 1) + 1;

  logic [PW-1:0]   pcnt;
  logic [MF_W-1:0] mcnt;
  logic [PW-1:0]   presc_last;
  logic [EW-1:0]   expo;
  logic            enabled;
  logic            p_end;
  logic            m_end;

  always_comb begin
    expo       = EW'(PRE_BASE) + EW'(presc_sel);
    presc_last = ({{(PW-1){1'b0}}, 1'b1} << expo) - {{(PW-1){1'b0}}, 1'b1};
    enabled    = (presc_sel != '0);
    p_end      = (pcnt == presc_last);
    m_end      = (mcnt == mod_sel);
    timeout    = run & enabled & ~restart & p_end & m_end;
  end

  always_ff @(posedge clk) begin
    if (rst || restart || !enabled) begin
      pcnt <= '0;
      mcnt <= '0;
    end else if (run) begin
      if (p_end) begin
        pcnt <= '0;
        mcnt <= m_end ? '0 : mcnt + 1'b1;
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  // R5: a restart leaves the count at zero
  p_restart_zero_r5: assert property (@(posedge clk) disable iff (rst)
    restart |=> (pcnt == '0 && mcnt == '0));

  // R4: after a timeout the next period starts from zero
  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (rst)
    timeout |=> (pcnt == '0 && mcnt == '0));

  // R2: modulus count stays within its limit
  p_mod_bound_r2: assert property (@(posedge clk) disable iff (rst)
    mcnt <= mod_sel);

  // R8: no selected tick, no movement
  p_halt_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!run && !restart) |=> ($stable(pcnt) && $stable(mcnt)));
endmodule

// File: rtl/rtt_flag.sv
module rtt_flag (
  input  logic clk,
  input  logic rst,
  input  logic timeout,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= timeout | (flag_q & ~clr);
  end

  assign flag = flag_q;
  assign irq  = flag_q & irq_en;

  // R10: a timeout always leaves the flag set
  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    timeout |=> flag_q);

  // R9: a clear with no timeout empties the flag
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (clr && !timeout) |=> !flag_q);

  // R9: without a clear the flag holds
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q);
endmodule

// File: rtl/rtt_top.sv
module rtt_top #(
  parameter int PRE_BASE = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_tick,
  input  logic       osc_tick,
  input  logic       stop_mode,
  input  logic       pseudo_stop,
  input  logic       osc_keep,
  input  logic       rate_we,
  input  logic [7:0] rate_wdata,
  input  logic       ctl_we,
  input  logic [1:0] ctl_wdata,
  input  logic       clr_we,
  input  logic       clr_wdata,
  output logic       flag,
  output logic       irq
);
  import rtt_pkg::*;

  logic [RATE_W-1:0] rate_q;
  rtt_ctl_t          ctl_q;
  logic              src_change;
  logic              restart;
  logic              run;
  logic              timeout;
  logic              clr;

  always_comb begin
    src_change = ctl_we && (ctl_wdata[CTL_SRC] != ctl_q.src_osc);
    restart    = rate_we | src_change;
    clr        = clr_we & clr_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= '0;
      ctl_q  <= '0;
    end else begin
      if (rate_we) rate_q <= rate_wdata;
      if (ctl_we) begin
        ctl_q.src_osc <= ctl_wdata[CTL_SRC];
        ctl_q.irq_en  <= ctl_wdata[CTL_IEN];
      end
    end
  end

  rtt_src_gate u_gate (
    .ref_tick    (ref_tick),
    .osc_tick    (osc_tick),
    .src_osc     (ctl_q.src_osc),
    .stop_mode   (stop_mode),
    .pseudo_stop (pseudo_stop),
    .osc_keep    (osc_keep),
    .run         (run)
  );

  rtt_count #(
    .PRE_BASE (PRE_BASE),
    .PF_W     (PF_W),
    .MF_W     (MF_W)
  ) u_count (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .restart   (restart),
    .presc_sel (rate_q[RATE_W-1:MF_W]),
    .mod_sel   (rate_q[MF_W-1:0]),
    .timeout   (timeout)
  );

  rtt_flag u_flag (
    .clk     (clk),
    .rst     (rst),
    .timeout (timeout),
    .clr     (clr),
    .irq_en  (ctl_q.irq_en),
    .flag    (flag),
    .irq     (irq)
  );

  // R11: no request without the enable bit
  p_irq_needs_en_r11: assert property (@(posedge clk) disable iff (rst)
    irq |-> ctl_q.irq_en);

  // R3: a zero prescale field never yields a flag rise
  p_disabled_r3: assert property (@(posedge clk) disable iff (rst)
    (rate_q[RATE_W-1:MF_W] == '0 && !flag && !rate_we) |=> !flag);
endmodule

// File: tb/rtt_top_tb_top.sv
module rtt_top_tb_top;
  localparam int PB = 1;

  logic       clk = 1'b0;
  logic       rst;
  logic       ref_tick, osc_tick, stop_mode, pseudo_stop, osc_keep;
  logic       rate_we, ctl_we, clr_we, clr_wdata;
  logic [7:0] rate_wdata;
  logic [1:0] ctl_wdata;
  logic       flag, irq;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  rtt_top #(.PRE_BASE(PB)) dut_i (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .osc_tick(osc_tick),
    .stop_mode(stop_mode), .pseudo_stop(pseudo_stop), .osc_keep(osc_keep),
    .rate_we(rate_we), .rate_wdata(rate_wdata), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .clr_we(clr_we), .clr_wdata(clr_wdata),
    .flag(flag), .irq(irq)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int period(int p, int m);
    return (m + 1) * (1 << (PB + p));
  endfunction

  task automatic wr_rate(logic [7:0] v);
    @(negedge clk); rate_we = 1'b1; rate_wdata = v;
    @(posedge clk); @(negedge clk); rate_we = 1'b0;
  endtask

  task automatic wr_ctl(logic [1:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(posedge clk); @(negedge clk); ctl_we = 1'b0;
  endtask

  // starts at a negedge; the write edge is the one just crossed
  task automatic wr_clr(logic d);
    clr_we = 1'b1; clr_wdata = d;
    @(posedge clk); @(negedge clk); clr_we = 1'b0;
  endtask

  task automatic edges_to_flag(int lim, output int n);
    n = 0;
    for (int i = 0; i < lim; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (flag) return;
    end
    n = -1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 flag", flag, 0);
    check("R1 irq", irq, 0);
    ref_tick = 1'b1;
    repeat (40) @(negedge clk);
    check("R1 disabled after reset", flag, 0);
  endtask

  task automatic t_period();
    int n;
    wr_ctl(2'b00);
    wr_rate(8'h12);
    edges_to_flag(200, n);
    check("R2 period P1 M2", n, period(1, 2));
    wr_clr(1'b1);
    check("R9 clear", flag, 0);
    edges_to_flag(200, n);
    check("R4 back-to-back period", n, period(1, 2) - 1);
    wr_rate(8'h20);
    wr_clr(1'b1);
    edges_to_flag(200, n);
    check("R2 period P2 M0", n, period(2, 0) - 1);
  endtask

  task automatic t_disabled();
    wr_rate(8'h05);
    wr_clr(1'b1);
    repeat (100) @(negedge clk);
    check("R3 zero prescale", flag, 0);
  endtask

  task automatic t_restart();
    int n;
    wr_rate(8'h12);
    wr_clr(1'b1);
    repeat (7) @(negedge clk);
    wr_rate(8'h12);
    edges_to_flag(200, n);
    check("R5 rewrite restarts", n, period(1, 2));
  endtask

  task automatic t_source();
    int n;
    wr_clr(1'b1);
    wr_ctl(2'b10);
    ref_tick = 1'b1; osc_tick = 1'b0;
    repeat (60) @(negedge clk);
    check("R6 reference ignored on osc", flag, 0);
    wr_ctl(2'b00);
    repeat (8) @(negedge clk);
    osc_tick = 1'b1;
    wr_ctl(2'b10);
    edges_to_flag(200, n);
    check("R7 source change restarts", n, period(1, 2));
  endtask

  task automatic t_stop();
    int n;
    wr_ctl(2'b00);
    wr_clr(1'b1);
    wr_rate(8'h12);
    repeat (5) @(posedge clk);
    @(negedge clk);
    stop_mode = 1'b1; pseudo_stop = 1'b1; osc_keep = 1'b1;
    repeat (30) @(negedge clk);
    check("R8 frozen on reference", flag, 0);
    stop_mode = 1'b0;
    edges_to_flag(200, n);
    check("R8 resume from held count", n, period(1, 2) - 5);
    wr_clr(1'b1);
    wr_ctl(2'b10);
    stop_mode = 1'b1; osc_keep = 1'b0;
    repeat (40) @(negedge clk);
    check("R8 frozen without keep", flag, 0);
    osc_keep = 1'b1;
    wr_rate(8'h12);
    edges_to_flag(200, n);
    check("R8 runs in pseudo stop", n, period(1, 2));
    stop_mode = 1'b0; pseudo_stop = 1'b0;
  endtask

  task automatic t_clear_rules();
    wr_clr(1'b0);
    check("R9 zero write ignored", flag, 1);
    wr_clr(1'b1);
    wr_rate(8'h12);
    repeat (period(1, 2) - 1) @(posedge clk);
    @(negedge clk);
    check("R10 not yet set", flag, 0);
    wr_clr(1'b1);
    check("R10 set beats clear", flag, 1);
  endtask

  task automatic t_irq();
    wr_ctl(2'b10);
    check("R11 masked", irq, 0);
    wr_ctl(2'b11);
    check("R11 asserted", irq, 1);
    wr_clr(1'b1);
    check("R11 drops with flag", irq, 0);
  endtask

  initial begin
    rst = 1'b1;
    {ref_tick, osc_tick, stop_mode, pseudo_stop, osc_keep} = '0;
    {rate_we, ctl_we, clr_we, clr_wdata} = '0;
    rate_wdata = '0; ctl_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    fork
      begin
        t_reset();
        t_period();
        t_disabled();
        t_restart();
        t_source();
        t_stop();
        t_clear_rules();
        t_irq();
      end
      begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule